// File: doc/BRIEF.md
# Bus Controller Initialization Gate

This block sequences the bring-up of a PCI-style bus interface controller after power-on. It holds two control bits: an enable bit and a set-only configuration-done bit. It also holds a small file of configuration registers that software fills in during bring-up. From these bits and a static host/normal mode input it decides four things. It decides whether CPU register accesses take effect. It decides whether inbound accesses from external bus devices are accepted or told to retry. It decides whether outbound accesses from the controller are granted or blocked. It decides whether bus arbitration passes through or is bypassed in favour of the controller itself.

Software first sets the enable bit. With configuration-done still 0, it then loads the configuration registers: command, status, subsystem identifiers, two local space sizes and two local base addresses. Last, it sets configuration-done. From then on, inbound traffic is accepted, outbound traffic is granted and, in host mode, the external arbiter's grants reach the bus. An outbound request made too early is refused and raises a one-cycle error pulse, so it does not stall.

Top module: `bus_init_gate`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the enable bit, the configuration-done bit and every configuration register are 0.
- R2: Address 0 is the enable register, with the enable bit at bit 0. The CPU can always write it and read it back, whatever the state of the enable bit.
- R3: While the enable bit is 0, a CPU write to any address other than 0 has no effect, and a read of any address other than 0 returns 0.
- R4: While the enable bit is 1, the configuration registers at addresses 2 to 9 are written by the CPU and read back in full. A read of an address that is not mapped returns 0. The read data is 0 whenever cpu_rd is low.
- R5: Address 1 is the control register, with configuration-done at bit 0. While enabled, a write with bit 0 set makes configuration-done 1 from the next cycle on, and reads of address 1 return it at bit 0.
- R6: Configuration-done is set-only. Writing 0 to it, or clearing the enable bit, leaves it at 1 until the next reset.
- R7: An inbound request gets in_retry while configuration-done is 0 and in_accept once it is 1. This holds in both modes. Neither response is raised without a request.
- R8: An outbound request gets out_blocked while configuration-done is 0 and out_grant once it is 1.
- R9: out_err is high for exactly one cycle. It is raised in the cycle after the first cycle of each uninterrupted run of blocked outbound requests.
- R10: In host mode while configuration-done is 0, arbitration is bypassed. The grant output is the value 1 (only master 0, the controller, is granted) and every request output is 0.
- R11: In normal mode, and in host mode once configuration-done is 1, arbitration requests and grants pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | ADDR_W | CPU register address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read data, combinational |
| host_mode | input | 1 | 1 = host (arbitration owner), 0 = normal |
| in_req | input | 1 | Inbound access request from the bus |
| in_accept | output | 1 | Inbound access accepted |
| in_retry | output | 1 | Inbound access answered with retry |
| out_req | input | 1 | Outbound access request from the controller |
| out_grant | output | 1 | Outbound access may proceed |
| out_blocked | output | 1 | Outbound access refused |
| out_err | output | 1 | One-cycle pulse on a newly blocked outbound request |
| arb_req_in | input | N_MST | Bus requests toward the arbiter |
| arb_req_out | output | N_MST | Gated requests to the external arbiter |
| arb_gnt_in | input | N_MST | Grants from the external arbiter, bit 0 = controller |
| arb_gnt_out | output | N_MST | Grants driven onto the bus |

## Verification
The main gating function is exercised across the whole bring-up order. It is also exercised with the order broken: configuration writes and control writes issued before enable, enable toggled off after configuration-done, and outbound requests held, dropped and re-raised. Patterns in host mode and in normal mode are run before and after configuration-done. This separates the bypass of arbitration from the pass-through, and separates retry from accept. A long stretch of random CPU, inbound, outbound and arbitration traffic follows, compared against the reference model on every cycle. It catches ordering mistakes, such as configuration-done being set while the enable bit is 0, or the error pulse repeating during a held request.

// File: rtl/big_pkg.sv
// Package: register address map shared by the initialization gate.
// Assumes configuration registers occupy a contiguous window after control.
package big_pkg;
    localparam int unsigned ADDR_ENABLE = 0;  // enable register
    localparam int unsigned ADDR_CTRL   = 1;  // control register (cfg done)
    localparam int unsigned ADDR_CFG0   = 2;  // first configuration register

    typedef enum logic [1:0] {
        RS_LOCKED  = 2'd0,   // enable 0: registers ignored
        RS_CONFIG  = 2'd1,   // enable 1, done 0: configuration phase
        RS_RUNNING = 2'd2    // done 1: traffic open
    } run_state_e;
endpackage

// File: rtl/big_regs.sv
// Module: CPU register file holding the enable bit, the set-only
// configuration-done bit and NUM_CFG configuration registers.
// Assumes single-cycle strobes; read data is combinational.
module big_regs
    import big_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_CFG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              enable_o,
    output logic              cfg_done_o
);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADDR_ENABLE);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);

    logic              en_q;
    logic              done_q;
    logic [DATA_W-1:0] cfg_q [NUM_CFG];
    logic              sel_en;
    logic              sel_ctrl;
    logic [NUM_CFG-1:0] sel_cfg;
    run_state_e        state;

    assign sel_en   = (cpu_addr == A_EN);
    assign sel_ctrl = (cpu_addr == A_CTRL);

    // Enable bit: always writable by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (cpu_wr && sel_en)
            en_q <= cpu_wdata[0];
    end

    // Configuration-done: set-only, and only while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (cpu_wr && en_q && sel_ctrl && cpu_wdata[0])
            done_q <= 1'b1;
    end

    // One configuration register per slot, written only while enabled.
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        localparam logic [ADDR_W-1:0] A_SLOT = ADDR_W'(ADDR_CFG0 + g);
        assign sel_cfg[g] = (cpu_addr == A_SLOT);
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[g] <= '0;
            else if (cpu_wr && en_q && sel_cfg[g])
                cfg_q[g] <= cpu_wdata;
        end
    end

    // Phase summary used by the read path.
    always_comb begin
        if (done_q)
            state = RS_RUNNING;
        else if (en_q)
            state = RS_CONFIG;
        else
            state = RS_LOCKED;
    end

    // Read mux: enable register always visible, others only when enabled.
    always_comb begin
        cpu_rdata = '0;
        if (cpu_rd) begin
            if (sel_en) begin
                cpu_rdata[0] = en_q;
            end else if (en_q) begin
                if (sel_ctrl)
                    cpu_rdata[0] = (state == RS_RUNNING);
                for (int i = 0; i < NUM_CFG; i++)
                    if (sel_cfg[i])
                        cpu_rdata = cfg_q[i];
            end
        end
    end

    assign enable_o   = en_q;
    assign cfg_done_o = done_q;

    AST_RST_CLEAR: assert property (@(posedge clk) !rst_n |=> (!en_q && !done_q)); // R1
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> done_q); // R6
    AST_LOCKED_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n) (!en_q && !done_q) |=> !done_q); // R3
    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (cpu_wr && sel_en) |=> (en_q == $past(cpu_wdata[0]))); // R2
endmodule

// File: rtl/big_access.sv
// Module: gates inbound (target) and outbound (master) accesses on the
// configuration-done bit and emits a one-cycle error on refused outbound
// requests. Assumes request inputs are synchronous to clk.
module big_access (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_done,
    input  logic in_req,
    output logic in_accept,
    output logic in_retry,
    input  logic out_req,
    output logic out_grant,
    output logic out_blocked,
    output logic out_err
);
    logic blk;
    logic prev_blk_q;
    logic err_q;

    // Inbound response: retry until configuration completes.
    always_comb begin
        in_accept = in_req &&  cfg_done;
        in_retry  = in_req && !cfg_done;
    end

    // Outbound response: refuse until configuration completes.
    always_comb begin
        out_grant = out_req &&  cfg_done;
        blk       = out_req && !cfg_done;
    end
    assign out_blocked = blk;

    // Error pulse on the first cycle of each run of blocked requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_blk_q <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            prev_blk_q <= blk;
            err_q      <= blk && !prev_blk_q;
        end
    end
    assign out_err = err_q;

    AST_IN_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n) in_req |-> (in_accept != in_retry)); // R7
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (out_req && !cfg_done) |-> (!out_grant && out_blocked)); // R8
    AST_ERR_ONE: assert property (@(posedge clk) disable iff (!rst_n) out_err |=> !out_err); // R9
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) out_err |-> $past(out_blocked)); // R9
endmodule

// File: rtl/big_arb.sv
// Module: arbitration gate. In host mode before configuration completes it
// grants the bus to master 0 (the controller) and hides requests; otherwise
// it passes requests and grants through. Assumes bit 0 is the controller.
module big_arb #(
    parameter int unsigned N_MST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_mode,
    input  logic             cfg_done,
    input  logic [N_MST-1:0] arb_req_in,
    input  logic [N_MST-1:0] arb_gnt_in,
    output logic [N_MST-1:0] arb_req_out,
    output logic [N_MST-1:0] arb_gnt_out
);
    logic bypass;

    assign bypass = host_mode && !cfg_done;

    // Per-master gating: self grant for bit 0 during bypass, pass otherwise.
    for (genvar m = 0; m < N_MST; m++) begin : g_mst
        localparam logic SELF = (m == 0);
        assign arb_gnt_out[m] = bypass ? SELF : arb_gnt_in[m];
        assign arb_req_out[m] = bypass ? 1'b0 : arb_req_in[m];
    end

    AST_SELF_OWN: assert property (@(posedge clk) disable iff (!rst_n) (host_mode && !cfg_done) |-> (arb_gnt_out[0] && $countones(arb_gnt_out) == 1 && arb_req_out == '0)); // R10
    AST_PASS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n) !host_mode |-> (arb_gnt_out == arb_gnt_in && arb_req_out == arb_req_in)); // R11
endmodule

// File: rtl/bus_init_gate.sv
// Module: top of the bus controller initialization gate. Connects the
// register file, the access gate and the arbitration gate.
// Assumes host_mode is static after reset.
module bus_init_gate #(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_CFG = 8,
    parameter int unsigned N_MST   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              host_mode,
    input  logic              in_req,
    output logic              in_accept,
    output logic              in_retry,
    input  logic              out_req,
    output logic              out_grant,
    output logic              out_blocked,
    output logic              out_err,
    input  logic [N_MST-1:0]  arb_req_in,
    output logic [N_MST-1:0]  arb_req_out,
    input  logic [N_MST-1:0]  arb_gnt_in,
    output logic [N_MST-1:0]  arb_gnt_out
);
    logic enable;
    logic cfg_done;

    big_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NUM_CFG(NUM_CFG)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .enable_o  (enable),
        .cfg_done_o(cfg_done)
    );

    big_access u_access (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_done   (cfg_done),
        .in_req     (in_req),
        .in_accept  (in_accept),
        .in_retry   (in_retry),
        .out_req    (out_req),
        .out_grant  (out_grant),
        .out_blocked(out_blocked),
        .out_err    (out_err)
    );

    big_arb #(
        .N_MST(N_MST)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_mode  (host_mode),
        .cfg_done   (cfg_done),
        .arb_req_in (arb_req_in),
        .arb_gnt_in (arb_gnt_in),
        .arb_req_out(arb_req_out),
        .arb_gnt_out(arb_gnt_out)
    );

    AST_DONE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) $rose(cfg_done) |-> $past(enable)); // R5
endmodule

// File: tb/tb_bus_init_gate.sv
module tb_bus_init_gate;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int NC = 8;
    localparam int NM = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          host_mode = 1'b1;
    logic          in_req = 1'b0, in_accept, in_retry;
    logic          out_req = 1'b0, out_grant, out_blocked, out_err;
    logic [NM-1:0] arb_req_in = '0, arb_req_out, arb_gnt_in = '0, arb_gnt_out;

    int total = 0;
    int bad = 0;

    // Reference model state
    int          m_en, m_done, m_prev, m_err;
    logic [DW-1:0] m_cfg [NC];

    bus_init_gate dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .host_mode(host_mode), .in_req(in_req), .in_accept(in_accept),
        .in_retry(in_retry), .out_req(out_req), .out_grant(out_grant),
        .out_blocked(out_blocked), .out_err(out_err),
        .arb_req_in(arb_req_in), .arb_req_out(arb_req_out),
        .arb_gnt_in(arb_gnt_in), .arb_gnt_out(arb_gnt_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_en = 0; m_done = 0; m_prev = 0; m_err = 0;
        for (int i = 0; i < NC; i++) m_cfg[i] = '0;
    endtask

    // Compare all outputs against the model (called away from the edge).
    task automatic compare();
        logic [DW-1:0] er;
        string lbl;
        int a;
        a = int'(cpu_addr);
        er = '0;
        if (a == 0) lbl = "R2";
        else if (!m_en) lbl = "R3";
        else if (a == 1) lbl = "R5";
        else lbl = "R4";
        if (cpu_rd) begin
            if (a == 0) er = DW'(m_en);
            else if (m_en != 0) begin
                if (a == 1) er = DW'(m_done);
                else if (a >= 2 && a < 2 + NC) er = m_cfg[a-2];
            end
        end
        chk(lbl, 64'(cpu_rdata), 64'(er));
        chk("R7", {in_accept, in_retry}, {in_req && m_done != 0, in_req && m_done == 0});
        chk("R8", {out_grant, out_blocked}, {out_req && m_done != 0, out_req && m_done == 0});
        chk("R9", 64'(out_err), 64'(m_err));
        if (host_mode && m_done == 0)
            chk("R10", {arb_gnt_out, arb_req_out}, {NM'(1), NM'(0)});
        else
            chk("R11", {arb_gnt_out, arb_req_out}, {arb_gnt_in, arb_req_in});
    endtask

    // One cycle: compare, clock the model, return at the next falling edge.
    task automatic step();
        int blkv;
        int a;
        #1 compare();
        @(posedge clk);
        a = int'(cpu_addr);
        if (!rst_n) model_reset();
        else begin
            blkv = (out_req && m_done == 0) ? 1 : 0;
            m_err = (blkv != 0 && m_prev == 0) ? 1 : 0;
            m_prev = blkv;
            if (cpu_wr) begin
                if (a == 0) m_en = int'(cpu_wdata[0]);
                else if (m_en != 0) begin
                    if (a == 1) begin
                        if (cpu_wdata[0]) m_done = 1;
                    end else if (a >= 2 && a < 2 + NC) m_cfg[a-2] = cpu_wdata;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        cpu_wr = 1'b1; cpu_addr = AW'(a); cpu_wdata = d;
        step();
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input int a);
        cpu_rd = 1'b1; cpu_addr = AW'(a);
        step();
        cpu_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk); model_reset();
        @(posedge clk);
        @(negedge clk);
        step();
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        // R1: reset state through the ports
        cpu_rd = 1'b1; cpu_addr = 0; #1 chk("R1", 64'(cpu_rdata), 0); cpu_rd = 1'b0;
        in_req = 1'b1; #1 chk("R1", 64'(in_retry), 1); in_req = 1'b0;
        // R3: writes before enable are ignored
        wr(2, 32'hDEAD_BEEF);
        wr(1, 32'h1);
        rd(2); rd(1);
        in_req = 1'b1; step(); in_req = 1'b0;
        // R10 host bypass, R9 error pulse with held request
        arb_req_in = 4'b1010; arb_gnt_in = 4'b0100;
        out_req = 1'b1; repeat (3) step(); out_req = 1'b0; step();
        out_req = 1'b1; step(); out_req = 1'b0; step(); step();
        // R11 normal mode passes through before done; R7 retry in normal mode
        host_mode = 1'b0; in_req = 1'b1; repeat (2) step(); in_req = 1'b0;
        host_mode = 1'b1;
        // R2 enable register toggles
        wr(0, 32'h1); rd(0); wr(0, 32'h0); rd(0); wr(0, 32'h1);
        // R4 configuration registers
        for (int i = 0; i < NC; i++) wr(2 + i, 32'h1000_0000 + 32'(i * 32'h0101_0111));
        for (int i = 0; i < NC; i++) rd(2 + i);
        rd(12); rd(15);
        cpu_addr = 3; #1 chk("R4", 64'(cpu_rdata), 0);
        // R5/R6: write 0 then 1 then 0
        wr(1, 32'h0); rd(1);
        out_req = 1'b1; step();
        wr(1, 32'h1);
        rd(1); step();
        out_req = 1'b0;
        wr(1, 32'h0); rd(1);
        in_req = 1'b1; #1 chk("R6", 64'(in_accept), 1); step();
        wr(0, 32'h0);
        #1 chk("R6", 64'(in_accept), 1); in_req = 1'b0;
        wr(0, 32'h1); rd(1);
        // R11 host pass-through after done
        arb_gnt_in = 4'b0010; out_req = 1'b1; repeat (2) step(); out_req = 1'b0;
        // Random traffic from a fresh reset, both modes
        for (int seg = 0; seg < 4; seg++) begin
            host_mode = seg[0];
            do_reset();
            for (int c = 0; c < 400; c++) begin
                int r;
                r = int'($urandom_range(0, 99));
                cpu_wr = (r < 10);
                cpu_rd = (r >= 10 && r < 40);
                cpu_addr = AW'($urandom_range(0, 15));
                cpu_wdata = $urandom();
                if (cpu_wr && cpu_addr == 1 && c < 150 * (seg + 1) / 2) cpu_wdata[0] = 1'b0;
                in_req = 1'($urandom_range(0, 1));
                out_req = ($urandom_range(0, 3) != 0);
                arb_req_in = NM'($urandom());
                arb_gnt_in = NM'($urandom());
                step();
            end
            cpu_wr = 1'b0; cpu_rd = 1'b0;
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule